// File: doc/BRIEF.md
# Banked Pin Configuration Register File

This block holds the configuration of a row of general-purpose pins behind a narrow byte-wide register bus. Every pin owns exactly one bus address, and that one address leads to six internal configuration banks. A host byte carries a bank number and a store flag. With the flag set, the low nibble is written into the named bank. With the flag clear, the byte only chooses which bank the next read of that pin returns. Reads are combinational on the address.

On the pad side the block turns each pin's stored state into an output enable, a driven level, an open-drain indication and a high-impedance control. It also registers the pad's input level and presents it with the pin's polarity applied. Supply-selection, bias-current and function-select codes are not acted on here. They are kept and handed to neighbouring logic on flat export buses.

Top module: `pin_cfg_bank_file`

## Requirements
- R1: Pin n answers at address BASE_ADDR + n for n from 0 to NUM_PINS-1 (defaults 0x150 and 8, NUM_PINS up to 44). A write to any other address changes nothing, and a read of any other address returns 0x00.
- R2: A written byte with bit 7 clear and bits [6:4] holding a bank number from 0 to 5 makes that bank the pin's read bank. A read returns bit 7 = 0, the read bank in bits [6:4] and that bank's contents in bits [3:0].
- R3: A written byte with bit 7 set stores its low bits into the bank named in bits [6:4] and leaves the pin's read bank unchanged.
- R4: A written byte whose bank field is 6 or 7 is ignored, whether bit 7 is set or clear. It changes no bank, no read bank and no pad output.
- R5: Bank layouts (bits [3:0] of both the store byte and the read byte). Bank 0: supply code [3:1], enable [0]. Bank 1: mode [3:2] (0 input, 1 both, 2 output, 3 off), open-drain [1], output value [0]. Bank 2: bias code [3:1], read bit 0 = 0. Bank 3: drive strength [3:2], read bit 1 = 0, disable [0]. Bank 4: function code [3:1], read bit 0 = 0. Bank 5: polarity [3] (1 = normal, 0 = inverted), read bits [2:0] = 0.
- R6: After reset every bank field is 0 except the bank 5 polarity bit, which is 1, and every pin's read bank is 0.
- R7: pad_oe for a pin is 1 only when all of the following hold: enable is 1, mode bit 1 is 1, drive strength is nonzero and disable is 0. pad_out is 0 whenever pad_oe is 0.
- R8: The logical output level is the output value, inverted when the polarity bit is 0. For a push-pull pin with pad_oe at 1, pad_out equals that level.
- R9: With open-drain selected, a logical 0 drives pad_oe = 1 and pad_out = 0, and a logical 1 releases pad_oe. pad_od shows the open-drain bit and pad_hiz shows the disable bit.
- R10: pin_level shows the pad_in value captured at the previous clock edge, inverted when the polarity bit is 0.
- R11: cfg_vsrc, cfg_bias, cfg_func and cfg_drive carry each pin's stored supply, bias, function and drive codes, with pin n at field n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address and byte |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write byte: store flag, bank field, payload |
| bus_rdata | output | 8 | Read byte for the addressed pin |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_out | output | NUM_PINS | Pad driven levels |
| pad_od | output | NUM_PINS | Open-drain select per pin |
| pad_hiz | output | NUM_PINS | High-impedance control per pin |
| pin_level | output | NUM_PINS | Registered input level with polarity applied |
| cfg_vsrc | output | 3*NUM_PINS | Supply selection codes |
| cfg_bias | output | 3*NUM_PINS | Bias codes |
| cfg_func | output | 3*NUM_PINS | Function codes |
| cfg_drive | output | 2*NUM_PINS | Drive strength codes |

## Verification
A wrong bank field or a stray write shows on the export buses and pad pins on the first clock edge after the bad write, so the bench compares every pin's pads and codes after every cycle. A wrong read bank is hidden until a read occurs. For that reason the random stream often follows a select-only byte with an immediate read and compares the whole byte, including the echoed bank number. Polarity faults show on pin_level one edge after pad_in moves.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef struct packed {
        logic       en;
        logic [2:0] vsrc;
        logic [1:0] mode;
        logic       od;
        logic       outv;
        logic [2:0] bias;
        logic [1:0] drive;
        logic       dis;
        logic [2:0] func;
        logic       noinv;
        logic [2:0] sel;
        logic       in_q;
    } pin_state_t;

    localparam logic [2:0] LAST_BANK = 3'd5;

    function automatic pin_state_t pin_reset_value();
        pin_state_t s;
        s       = '0;
        s.noinv = 1'b1;
        return s;
    endfunction

    function automatic logic [7:0] bank_read(input pin_state_t s);
        logic [3:0] low;
        case (s.sel)
            3'd0:    low = {s.vsrc, s.en};
            3'd1:    low = {s.mode, s.od, s.outv};
            3'd2:    low = {s.bias, 1'b0};
            3'd3:    low = {s.drive, 1'b0, s.dis};
            3'd4:    low = {s.func, 1'b0};
            3'd5:    low = {s.noinv, 3'b000};
            default: low = 4'h0;
        endcase
        return {1'b0, s.sel, low};
    endfunction

endpackage

// File: rtl/pcfg_decode.sv
module pcfg_decode #(
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned BASE_ADDR = 336,
    parameter int unsigned NUM_PINS  = 8,
    parameter int unsigned IDX_W     = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] BASE_X = BASE_ADDR[ADDR_W:0];
    localparam logic [ADDR_W:0] NUM_X  = NUM_PINS[ADDR_W:0];

    logic [ADDR_W:0] off;

    always_comb begin
        off = {1'b0, addr} - BASE_X;
        hit = !off[ADDR_W] && (off < NUM_X);
        idx = off[IDX_W-1:0];
    end
endmodule

// File: rtl/pcfg_pin.sv
module pcfg_pin
    import pcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       pad_in,
    output pin_state_t st
);
    pin_state_t st_d, st_q;
    logic [2:0] bank;

    always_comb begin
        st_d      = st_q;
        bank      = wdata[6:4];
        st_d.in_q = pad_in;
        if (wr_en) begin
            if (wdata[7]) begin
                case (bank)
                    3'd0: begin
                        st_d.vsrc = wdata[3:1];
                        st_d.en   = wdata[0];
                    end
                    3'd1: begin
                        st_d.mode = wdata[3:2];
                        st_d.od   = wdata[1];
                        st_d.outv = wdata[0];
                    end
                    3'd2: st_d.bias = wdata[3:1];
                    3'd3: begin
                        st_d.drive = wdata[3:2];
                        st_d.dis   = wdata[0];
                    end
                    3'd4: st_d.func  = wdata[3:1];
                    3'd5: st_d.noinv = wdata[3];
                    default: ;
                endcase
            end else if (bank <= LAST_BANK) begin
                st_d.sel = bank;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= pin_reset_value();
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/pcfg_pad.sv
module pcfg_pad
    import pcfg_pkg::*;
(
    input  pin_state_t st,
    output logic       oe,
    output logic       out,
    output logic       od,
    output logic       hiz,
    output logic       level
);
    logic active;
    logic lvl;

    always_comb begin
        active = st.en && st.mode[1] && (st.drive != 2'd0) && !st.dis;
        lvl    = st.outv ^ !st.noinv;
        oe     = active && !(st.od && lvl);
        out    = oe && lvl;
        od     = st.od;
        hiz    = st.dis;
        level  = st.in_q ^ !st.noinv;
    end
endmodule

// File: rtl/pin_cfg_bank_file.sv
module pin_cfg_bank_file
    import pcfg_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 8,
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned BASE_ADDR = 336
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_od,
    output logic [NUM_PINS-1:0]   pad_hiz,
    output logic [NUM_PINS-1:0]   pin_level,
    output logic [3*NUM_PINS-1:0] cfg_vsrc,
    output logic [3*NUM_PINS-1:0] cfg_bias,
    output logic [3*NUM_PINS-1:0] cfg_func,
    output logic [2*NUM_PINS-1:0] cfg_drive
);
    localparam int unsigned IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic             hit;
    logic [IDX_W-1:0] idx;
    pin_state_t       st [NUM_PINS];

    pcfg_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .NUM_PINS(NUM_PINS), .IDX_W(IDX_W)
    ) u_decode (
        .addr(bus_addr), .hit(hit), .idx(idx)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic wr_sel;
        assign wr_sel = bus_we && hit && (idx == IDX_W'(i));

        pcfg_pin u_pin (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_sel),
            .wdata(bus_wdata), .pad_in(pad_in[i]), .st(st[i])
        );

        pcfg_pad u_pad (
            .st(st[i]), .oe(pad_oe[i]), .out(pad_out[i]),
            .od(pad_od[i]), .hiz(pad_hiz[i]), .level(pin_level[i])
        );

        assign cfg_vsrc[3*i +: 3]  = st[i].vsrc;
        assign cfg_bias[3*i +: 3]  = st[i].bias;
        assign cfg_func[3*i +: 3]  = st[i].func;
        assign cfg_drive[2*i +: 2] = st[i].drive;
    end

    always_comb begin
        bus_rdata = 8'h00;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (hit && (idx == IDX_W'(i))) bus_rdata = bank_read(st[i]);
        end
    end
endmodule

// File: rtl/pcfg_checker.sv
module pcfg_checker #(
    parameter int unsigned NUM_PINS  = 8,
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned BASE_ADDR = 336
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [7:0]            bus_wdata,
    input logic [7:0]            bus_rdata,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_od,
    input logic [NUM_PINS-1:0]   pad_hiz,
    input logic [3*NUM_PINS-1:0] cfg_vsrc,
    input logic [3*NUM_PINS-1:0] cfg_bias,
    input logic [3*NUM_PINS-1:0] cfg_func,
    input logic [2*NUM_PINS-1:0] cfg_drive
);
    logic [31:0] a32;
    logic        in_map;
    assign a32    = 32'(bus_addr);
    assign in_map = (a32 >= BASE_ADDR) && (a32 < BASE_ADDR + NUM_PINS);

    // R2: the top bit of a read byte is always zero
    assert_rdata_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7] == 1'b0);

    // R1: writes outside the pin window leave every pin untouched
    assert_unmapped_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !in_map) |=> ($stable(cfg_vsrc) && $stable(cfg_bias) &&
            $stable(cfg_func) && $stable(cfg_drive) && $stable(pad_oe) &&
            $stable(pad_od) && $stable(pad_hiz)));

    // R4: bank numbers 6 and 7 are ignored
    assert_bank_high_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata[6:5] == 2'b11) |=> ($stable(cfg_vsrc) && $stable(cfg_bias) &&
            $stable(cfg_func) && $stable(cfg_drive) && $stable(pad_oe) &&
            $stable(pad_out) && $stable(pad_od) && $stable(pad_hiz)));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R7: drive needs nonzero strength and no high-impedance request
        assert_oe_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[i] |-> (cfg_drive[2*i +: 2] != 2'd0 && !pad_hiz[i]));

        // R7: no driven level without an enable
        assert_out_needs_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !pad_oe[i] |-> !pad_out[i]);

        // R9: an open-drain pin never drives high
        assert_od_low_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
            pad_od[i] |-> !pad_out[i]);
    end
endmodule

bind pin_cfg_bank_file pcfg_checker #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_pcfg_checker (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_od(pad_od), .pad_hiz(pad_hiz),
    .cfg_vsrc(cfg_vsrc), .cfg_bias(cfg_bias), .cfg_func(cfg_func),
    .cfg_drive(cfg_drive)
);

// File: tb/pin_cfg_bank_file_bench.sv
`timescale 1ns/1ps
module pin_cfg_bank_file_bench;
    localparam int NP   = 8;
    localparam int AW   = 9;
    localparam int BASE = 336;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_oe, pad_out, pad_od, pad_hiz, pin_level;
    logic [3*NP-1:0] cfg_vsrc, cfg_bias, cfg_func;
    logic [2*NP-1:0] cfg_drive;

    always #2.5 clk = ~clk;

    pin_cfg_bank_file #(.NUM_PINS(NP), .ADDR_W(AW), .BASE_ADDR(BASE)) u_pin_cfg_bank_file (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od), .pad_hiz(pad_hiz),
        .pin_level(pin_level), .cfg_vsrc(cfg_vsrc), .cfg_bias(cfg_bias),
        .cfg_func(cfg_func), .cfg_drive(cfg_drive)
    );

    // reference model
    logic       m_en [NP];
    logic [2:0] m_vsrc [NP];
    logic [1:0] m_mode [NP];
    logic       m_od [NP];
    logic       m_outv [NP];
    logic [2:0] m_bias [NP];
    logic [1:0] m_drive [NP];
    logic       m_dis [NP];
    logic [2:0] m_func [NP];
    logic       m_noinv [NP];
    logic [2:0] m_sel [NP];
    logic       m_in [NP];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_en[p] = 0; m_vsrc[p] = 0; m_mode[p] = 0; m_od[p] = 0; m_outv[p] = 0;
            m_bias[p] = 0; m_drive[p] = 0; m_dis[p] = 0; m_func[p] = 0;
            m_noinv[p] = 1; m_sel[p] = 0; m_in[p] = 0;
        end
    endtask

    function automatic logic [7:0] exp_read(input int p);
        logic [3:0] low;
        case (m_sel[p])
            3'd0: low = {m_vsrc[p], m_en[p]};
            3'd1: low = {m_mode[p], m_od[p], m_outv[p]};
            3'd2: low = {m_bias[p], 1'b0};
            3'd3: low = {m_drive[p], 1'b0, m_dis[p]};
            3'd4: low = {m_func[p], 1'b0};
            default: low = {m_noinv[p], 3'b000};
        endcase
        return {1'b0, m_sel[p], low};
    endfunction

    function automatic logic exp_oe(input int p);
        logic act, lvl;
        act = m_en[p] && m_mode[p][1] && (m_drive[p] != 0) && !m_dis[p];
        lvl = m_outv[p] ^ !m_noinv[p];
        return act && !(m_od[p] && lvl);
    endfunction

    function automatic logic exp_out(input int p);
        return exp_oe(p) && (m_outv[p] ^ !m_noinv[p]);
    endfunction

    task automatic step(input bit we, input int addr, input logic [7:0] d, input logic [NP-1:0] pin);
        bus_we = we; bus_addr = AW'(addr); bus_wdata = d; pad_in = pin;
        @(posedge clk);
        for (int p = 0; p < NP; p++) m_in[p] = pin[p];
        if (we && addr >= BASE && addr < BASE + NP) begin
            int p;
            logic [2:0] b;
            p = addr - BASE;
            b = d[6:4];
            if (d[7]) begin
                case (b)
                    3'd0: begin m_vsrc[p] = d[3:1]; m_en[p] = d[0]; end
                    3'd1: begin m_mode[p] = d[3:2]; m_od[p] = d[1]; m_outv[p] = d[0]; end
                    3'd2: m_bias[p] = d[3:1];
                    3'd3: begin m_drive[p] = d[3:2]; m_dis[p] = d[0]; end
                    3'd4: m_func[p] = d[3:1];
                    3'd5: m_noinv[p] = d[3];
                    default: ;
                endcase
            end else if (b <= 3'd5) begin
                m_sel[p] = b;
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_read(input int p, input string req);
        bus_addr = AW'(BASE + p);
        #1;
        chk(bus_rdata == exp_read(p), req, bus_rdata, exp_read(p));
    endtask

    task automatic check_pads();
        for (int p = 0; p < NP; p++) begin
            chk(pad_oe[p] == exp_oe(p), "R7", pad_oe[p], exp_oe(p));
            chk(pad_out[p] == exp_out(p), "R8/R9", pad_out[p], exp_out(p));
            chk(pad_od[p] == m_od[p] && pad_hiz[p] == m_dis[p], "R9",
                {pad_od[p], pad_hiz[p]}, {m_od[p], m_dis[p]});
            chk(pin_level[p] == (m_in[p] ^ !m_noinv[p]), "R10", pin_level[p], m_in[p] ^ !m_noinv[p]);
            chk(cfg_vsrc[3*p +: 3] == m_vsrc[p] && cfg_bias[3*p +: 3] == m_bias[p] &&
                cfg_func[3*p +: 3] == m_func[p] && cfg_drive[2*p +: 2] == m_drive[p], "R11",
                {cfg_vsrc[3*p +: 3], cfg_bias[3*p +: 3], cfg_func[3*p +: 3], cfg_drive[2*p +: 2]},
                {m_vsrc[p], m_bias[p], m_func[p], m_drive[p]});
        end
    endtask

    initial begin
        int unsigned r;
        r = $urandom(32'd4711);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset state, bank 0 reads zero everywhere
        for (int p = 0; p < NP; p++) check_read(p, "R6");
        check_pads();
        // R6/R5: polarity bit resets to normal
        step(1, BASE + 0, 8'h50, '0);
        check_read(0, "R6_polarity");
        chk(bus_rdata == 8'h58, "R6", bus_rdata, 8'h58);

        // R1: unmapped addresses
        step(1, BASE - 1, 8'h81, '0);
        step(1, BASE + NP, 8'hBF, '0);
        check_pads();
        bus_addr = AW'(BASE + NP); #1;
        chk(bus_rdata == 8'h00, "R1", bus_rdata, 0);
        bus_addr = AW'(BASE - 1); #1;
        chk(bus_rdata == 8'h00, "R1", bus_rdata, 0);

        // R3: store leaves selector; R2 select then read
        step(1, BASE + 2, 8'h20, '0);
        step(1, BASE + 2, 8'hCE, '0);
        check_read(2, "R3");
        step(1, BASE + 2, 8'h40, '0);
        check_read(2, "R2");
        chk(bus_rdata == 8'h4E, "R5", bus_rdata, 8'h4E);

        // R4: bank 6 and 7 ignored
        step(1, BASE + 2, 8'hEF, '0);
        step(1, BASE + 2, 8'h70, '0);
        check_read(2, "R4");
        check_pads();

        // R7/R8/R9 directed: enable, output mode, drive 1
        step(1, BASE + 3, 8'h81, '0);
        step(1, BASE + 3, 8'h99, '0);
        step(1, BASE + 3, 8'hB4, '0);
        check_pads();
        chk(pad_oe[3] && pad_out[3], "R8", {pad_oe[3], pad_out[3]}, 2'b11);
        step(1, BASE + 3, 8'h9B, '0);
        check_pads();
        chk(!pad_oe[3], "R9", pad_oe[3], 0);
        step(1, BASE + 3, 8'hD0, '0);
        check_pads();
        chk(pad_oe[3] && !pad_out[3], "R9", {pad_oe[3], pad_out[3]}, 2'b10);
        step(1, BASE + 3, 8'hB5, 8'hFF);
        check_pads();
        chk(!pad_oe[3] && pad_hiz[3], "R7", {pad_oe[3], pad_hiz[3]}, 2'b01);

        // random mix
        for (int it = 0; it < 3000; it++) begin
            int addr;
            int p;
            logic [7:0] d;
            p = int'($urandom % NP);
            addr = BASE + p;
            if ($urandom % 10 == 0) addr = ($urandom % 2) ? BASE - 1 - int'($urandom % 4) : BASE + NP + int'($urandom % 8);
            d = 8'($urandom);
            if ($urandom % 3 == 0) begin
                d[7] = 1'b0;
                step(1, addr, d, NP'($urandom));
                if (addr >= BASE && addr < BASE + NP) check_read(p, "R2");
            end else begin
                step($urandom % 8 != 0, addr, d, NP'($urandom));
            end
            check_pads();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule